// File: doc/BRIEF.md
# Clock Divider Reconfiguration Sequencer

This block reprograms one output divider of a clock-management tile through the tile's dynamic reconfiguration register port. A requester gives a divide value and a start strobe. The divide value has an integer part and a fractional part counted in eighths. The sequencer splits the integer part into high and low counter times and builds the fractional field with its enable bit. It then writes two configuration registers, always the counter-time register first. The tile reset is held high for the whole time the registers are written.

When the second write has been acknowledged, the sequencer releases the tile reset and waits for the lock input to come back. It then gives a one-cycle done pulse. An integer divide outside the allowed range is refused with a one-cycle error pulse, and no write takes place. A missing ready acknowledge or a lock that never returns also ends the sequence with an error pulse, and the block goes back to idle.

Top module: `clkdiv_reprog_seq`

## Requirements
- R1: The two writes go to address 0x08 first and then to address 0x09. The second write is issued only after a ready pulse has acknowledged the first.
- R2: The word written to 0x08 carries the high time in bits [11:6] and the low time in bits [5:0]. For an integer divide N, high = floor(N/2) and low = N - high. All other bits are zero.
- R3: Each write holds enable and write-enable high together for exactly one clock cycle.
- R4: The word written to 0x09 carries the fraction in eighths in bits [14:12]. Bit 11 is set exactly when the fraction is non-zero. All other bits are zero, so an integer-only divide writes an all-zero word.
- R5: The tile reset rises on the clock edge that accepts a start. It stays high through both writes and falls on the edge that accepts the second ready pulse.
- R6: After the tile reset falls, busy stays high until lock is sampled high. Done then pulses for one cycle, on the same edge where busy falls. With a tile that relocks L cycles after release, done is first seen L+1 cycles after the tile reset is first seen low.
- R7: A start whose integer divide is below 2 or above 64 gives a one-cycle error pulse. It causes no write, no tile reset and no busy.
- R8: A wait for ready that reaches 64 cycles with no ready pulse ends with an error pulse and a return to idle, without done.
- R9: A wait for lock that reaches LOCK_TMO cycles ends with an error pulse and a return to idle, without done.
- R10: A start strobe that arrives while busy is high has no effect on the writes or on their data.
- R11: Out of reset, enable, write-enable, tile reset, busy, done and error are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe, one cycle |
| div_int_i | input | 7 | Integer part of the divide value |
| div_frac_i | input | 3 | Fractional part in eighths |
| cfg_addr_o | output | 7 | Register port address |
| cfg_wdata_o | output | 16 | Register port write data |
| cfg_en_o | output | 1 | Register port access enable |
| cfg_we_o | output | 1 | Register port write enable |
| cfg_rdy_i | input | 1 | Register port ready pulse |
| lock_i | input | 1 | Tile lock indication |
| tile_rst_o | output | 1 | Tile reset |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished with lock, one-cycle pulse |
| err_o | output | 1 | Rejection or timeout, one-cycle pulse |

## Verification
The assertions assume that a ready pulse arrives only after an access has been issued. They also assume that lock stays low while the tile reset is high, so that a stale lock cannot end the wait for relock. The bench's register-port model raises ready a fixed number of cycles after each enable. Its tile model clears lock while the tile reset is high and raises it a fixed number of cycles after release. The sweep covers every integer divide from 0 to 66 with every fraction. It then switches ready off, and separately lock off, to reach both timeouts.

// File: rtl/crs_pkg.sv
package crs_pkg;
  localparam int ADDR_W   = 7;
  localparam int DATA_W   = 16;
  localparam int FIELD_W  = 6;
  localparam int FRAC_W   = 3;
  localparam int HI_LSB   = 6;
  localparam int LO_LSB   = 0;
  localparam int FRAC_LSB = 12;
  localparam int FEN_BIT  = 11;
  localparam logic [ADDR_W-1:0] ADDR_CNT1 = 7'h08;
  localparam logic [ADDR_W-1:0] ADDR_CNT2 = 7'h09;

  typedef enum logic [2:0] {
    S_IDLE, S_WR1, S_WAIT1, S_WR2, S_WAIT2, S_REL, S_LOCK
  } seq_state_e;
endpackage

// File: rtl/crs_div_encode.sv
module crs_div_encode
  import crs_pkg::*;
#(
  parameter int INT_W   = 7,
  parameter int MIN_DIV = 2,
  parameter int MAX_DIV = 64
) (
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  output logic              ok,
  output logic [DATA_W-1:0] word_cnt1,
  output logic [DATA_W-1:0] word_cnt2
);
  logic [INT_W-1:0] hi_t;
  logic [INT_W-1:0] lo_t;

  always_comb begin
    ok = (div_int >= INT_W'(MIN_DIV)) && (div_int <= INT_W'(MAX_DIV));
    hi_t = div_int >> 1;
    lo_t = div_int - hi_t;
    word_cnt1 = '0;
    word_cnt1[HI_LSB +: FIELD_W] = hi_t[FIELD_W-1:0];
    word_cnt1[LO_LSB +: FIELD_W] = lo_t[FIELD_W-1:0];
    word_cnt2 = '0;
    word_cnt2[FRAC_LSB +: FRAC_W] = div_frac;
    word_cnt2[FEN_BIT] = |div_frac;
  end
endmodule

// File: rtl/crs_wait_timer.sv
module crs_wait_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             tick,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] count_d;

  always_comb begin
    count_d = count;
    if (clear)     count_d = '0;
    else if (tick) count_d = count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              count <= '0;
    else if (clear || tick)  count <= count_d;
  end
endmodule

// File: rtl/clkdiv_reprog_seq.sv
module clkdiv_reprog_seq
  import crs_pkg::*;
#(
  parameter int INT_W    = 7,
  parameter int MIN_DIV  = 2,
  parameter int MAX_DIV  = 64,
  parameter int RDY_TMO  = 64,
  parameter int LOCK_TMO = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [INT_W-1:0]  div_int_i,
  input  logic [FRAC_W-1:0] div_frac_i,
  output logic [ADDR_W-1:0] cfg_addr_o,
  output logic [DATA_W-1:0] cfg_wdata_o,
  output logic              cfg_en_o,
  output logic              cfg_we_o,
  input  logic              cfg_rdy_i,
  input  logic              lock_i,
  output logic              tile_rst_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int TMO_MAX = (RDY_TMO > LOCK_TMO) ? RDY_TMO : LOCK_TMO;
  localparam int CNT_W   = $clog2(TMO_MAX + 1);
  localparam logic [CNT_W-1:0] RDY_LAST  = CNT_W'(RDY_TMO - 1);
  localparam logic [CNT_W-1:0] LOCK_LAST = CNT_W'(LOCK_TMO - 1);

  seq_state_e state_q, state_d;
  logic [DATA_W-1:0] w1_q, w2_q, w1_c, w2_c;
  logic div_ok, load;
  logic done_q, done_d, err_q, err_d;
  logic tmr_clr, tmr_tick;
  logic [CNT_W-1:0] tmr_cnt;

  crs_div_encode #(.INT_W(INT_W), .MIN_DIV(MIN_DIV), .MAX_DIV(MAX_DIV)) u_enc (
    .div_int(div_int_i), .div_frac(div_frac_i),
    .ok(div_ok), .word_cnt1(w1_c), .word_cnt2(w2_c)
  );

  crs_wait_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clear(tmr_clr), .tick(tmr_tick), .count(tmr_cnt)
  );

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    done_d   = 1'b0;
    err_d    = 1'b0;
    tmr_clr  = 1'b0;
    tmr_tick = 1'b0;
    case (state_q)
      S_IDLE: if (start_i) begin
        if (div_ok) begin
          load    = 1'b1;
          state_d = S_WR1;
        end else begin
          err_d = 1'b1;
        end
      end
      S_WR1: begin
        tmr_clr = 1'b1;
        state_d = S_WAIT1;
      end
      S_WAIT1: begin
        if (cfg_rdy_i)                state_d = S_WR2;
        else if (tmr_cnt == RDY_LAST) begin err_d = 1'b1; state_d = S_IDLE; end
        else                          tmr_tick = 1'b1;
      end
      S_WR2: begin
        tmr_clr = 1'b1;
        state_d = S_WAIT2;
      end
      S_WAIT2: begin
        if (cfg_rdy_i)                state_d = S_REL;
        else if (tmr_cnt == RDY_LAST) begin err_d = 1'b1; state_d = S_IDLE; end
        else                          tmr_tick = 1'b1;
      end
      S_REL: begin
        tmr_clr = 1'b1;
        state_d = S_LOCK;
      end
      S_LOCK: begin
        if (lock_i)                    begin done_d = 1'b1; state_d = S_IDLE; end
        else if (tmr_cnt == LOCK_LAST) begin err_d = 1'b1; state_d = S_IDLE; end
        else                           tmr_tick = 1'b1;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w1_q <= '0;
      w2_q <= '0;
    end else if (load) begin
      w1_q <= w1_c;
      w2_q <= w2_c;
    end
  end

  always_comb begin
    cfg_en_o    = (state_q == S_WR1) || (state_q == S_WR2);
    cfg_we_o    = cfg_en_o;
    cfg_addr_o  = ((state_q == S_WR2) || (state_q == S_WAIT2)) ? ADDR_CNT2 : ADDR_CNT1;
    cfg_wdata_o = (state_q == S_WR2) ? w2_q : ((state_q == S_WR1) ? w1_q : '0);
    tile_rst_o  = (state_q == S_WR1) || (state_q == S_WAIT1) ||
                  (state_q == S_WR2) || (state_q == S_WAIT2);
    busy_o      = (state_q != S_IDLE);
    done_o      = done_q;
    err_o       = err_q;
  end

  AST_EN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en_o |=> !cfg_en_o); // R3
  AST_WRITE_UNDER_RST: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en_o |-> tile_rst_o); // R5
  AST_SECOND_AFTER_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en_o && cfg_addr_o == ADDR_CNT2) |-> $past(cfg_rdy_i)); // R1
  AST_FRAC_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en_o && cfg_addr_o == ADDR_CNT2) |->
      (cfg_wdata_o[FEN_BIT] == (cfg_wdata_o[FRAC_LSB +: FRAC_W] != '0))); // R4
  AST_DONE_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(lock_i)); // R6
  AST_END_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (done_o ^ err_o)); // R6
  AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en_o && cfg_addr_o == ADDR_CNT1) |->
      ((32'(cfg_wdata_o[HI_LSB +: FIELD_W]) + 32'(cfg_wdata_o[LO_LSB +: FIELD_W]) >= MIN_DIV) &&
       (32'(cfg_wdata_o[HI_LSB +: FIELD_W]) + 32'(cfg_wdata_o[LO_LSB +: FIELD_W]) <= MAX_DIV))); // R7
endmodule

// File: tb/clkdiv_reprog_seq_tb.sv
module clkdiv_reprog_seq_tb;
  localparam int LOCK_TMO = 40;
  localparam int RDY_DLY  = 2;
  localparam int LOCK_DLY = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [6:0] div_int = '0;
  logic [2:0] div_frac = '0;
  logic [6:0] addr;
  logic [15:0] wdata;
  logic en, we, rdy, lock, trst, busy, done, err;

  int checks = 0;
  int fails = 0;
  bit rdy_on = 1'b1;
  bit lock_on = 1'b1;

  always #2.5 clk = ~clk;

  clkdiv_reprog_seq #(.LOCK_TMO(LOCK_TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .div_int_i(div_int), .div_frac_i(div_frac),
    .cfg_addr_o(addr), .cfg_wdata_o(wdata), .cfg_en_o(en), .cfg_we_o(we),
    .cfg_rdy_i(rdy), .lock_i(lock), .tile_rst_o(trst), .busy_o(busy),
    .done_o(done), .err_o(err)
  );

  // register-port and tile models
  int rdy_cnt;
  int lk_cnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy <= 1'b0; rdy_cnt <= 0; lock <= 1'b1; lk_cnt <= 0;
    end else begin
      rdy <= 1'b0;
      if (en) rdy_cnt <= RDY_DLY;
      else if (rdy_cnt > 0) begin
        rdy_cnt <= rdy_cnt - 1;
        if (rdy_cnt == 1 && rdy_on) rdy <= 1'b1;
      end
      if (trst) begin
        lock <= 1'b0; lk_cnt <= LOCK_DLY;
      end else if (lk_cnt > 0) begin
        lk_cnt <= lk_cnt - 1;
        if (lk_cnt == 1 && lock_on) lock <= 1'b1;
      end
    end
  end

  // monitor
  int cyc = 0, wr_n = 0, done_n = 0, err_n = 0, rst_rises = 0, bad_pair = 0;
  int fall_cyc = 0, done_cyc = 0;
  logic [6:0]  wa [2];
  logic [15:0] wd [2];
  logic prev_rst = 1'b0;
  logic prev_en = 1'b0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    prev_rst <= trst;
    prev_en <= en;
    if (en !== we || (en && prev_en)) bad_pair <= bad_pair + 1;
    if (en) begin
      if (wr_n < 2) begin wa[wr_n] <= addr; wd[wr_n] <= wdata; end
      wr_n <= wr_n + 1;
    end
    if (trst && !prev_rst) rst_rises <= rst_rises + 1;
    if (!trst && prev_rst) fall_cyc <= cyc;
    if (done) begin done_n <= done_n + 1; done_cyc <= cyc; end
    if (err) err_n <= err_n + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr_mon();
    @(negedge clk);
    wr_n = 0; done_n = 0; err_n = 0; rst_rises = 0; bad_pair = 0;
  endtask

  task automatic pulse_start(input int n, input int f);
    @(negedge clk);
    div_int = 7'(n); div_frac = 3'(f); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (busy && guard < 500) begin @(negedge clk); guard++; end
    @(negedge clk);
  endtask

  task automatic run_one(input int n, input int f);
    int hi, lo;
    logic [15:0] e1, e2;
    hi = n / 2; lo = n - hi;
    e1 = 16'((hi << 6) | lo);
    e2 = 16'((f << 12) | ((f != 0) ? (1 << 11) : 0));
    clr_mon();
    pulse_start(n, f);
    wait_idle();
    if (n < 2 || n > 64) begin
      chk(err_n == 1, "R7 err pulse", err_n, 1);
      chk(wr_n == 0, "R7 no write", wr_n, 0);
      chk(rst_rises == 0, "R7 no tile reset", rst_rises, 0);
    end else begin
      chk(wr_n == 2, "R1 write count", wr_n, 2);
      chk(wa[0] == 7'h08 && wa[1] == 7'h09, "R1 address order", wa[0] * 256 + wa[1], 8 * 256 + 9);
      chk(wd[0] == e1, "R2 counter word", wd[0], e1);
      chk(wd[1] == e2, "R4 fraction word", wd[1], e2);
      chk(bad_pair == 0, "R3 enable pairing", bad_pair, 0);
      chk(rst_rises == 1, "R5 one tile reset", rst_rises, 1);
      chk(done_n == 1 && err_n == 0, "R6 single done", done_n * 10 + err_n, 10);
      chk(done_cyc - fall_cyc == LOCK_DLY + 1, "R6 relock wait", done_cyc - fall_cyc, LOCK_DLY + 1);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!en && !we && !trst && !busy && !done && !err, "R11 reset outputs",
        {en, we, trst, busy, done, err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!en && !trst && !busy && !done && !err, "R11 after release",
        {en, trst, busy, done, err}, 0);

    for (int n = 0; n <= 66; n++)
      for (int f = 0; f < 8; f++)
        run_one(n, f);

    // R10: start while busy
    clr_mon();
    pulse_start(20, 3);
    @(negedge clk);
    div_int = 7'd10; div_frac = 3'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    repeat (4) @(negedge clk);
    chk(wr_n == 2, "R10 write count", wr_n, 2);
    chk(wd[0] == 16'((10 << 6) | 10), "R10 first word kept", wd[0], (10 << 6) | 10);
    chk(wd[1] == 16'((3 << 12) | (1 << 11)), "R10 second word kept", wd[1], (3 << 12) | (1 << 11));
    chk(done_n == 1, "R10 single done", done_n, 1);

    // R8: ready never returns
    rdy_on = 1'b0;
    clr_mon();
    pulse_start(9, 1);
    wait_idle();
    chk(err_n == 1 && done_n == 0, "R8 ready timeout", err_n * 10 + done_n, 10);
    chk(wr_n == 1, "R8 stops after first write", wr_n, 1);
    chk(!busy && !trst, "R8 back to idle", {busy, trst}, 0);
    rdy_on = 1'b1;

    // R9: lock never returns
    lock_on = 1'b0;
    clr_mon();
    pulse_start(12, 0);
    wait_idle();
    chk(err_n == 1 && done_n == 0, "R9 lock timeout", err_n * 10 + done_n, 10);
    chk(wr_n == 2, "R9 both writes made", wr_n, 2);
    chk(!busy, "R9 back to idle", busy, 0);
    lock_on = 1'b1;

    // recovery after timeouts
    run_one(64, 7);
    run_one(2, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule